// File: doc/BRIEF.md
# Pipelined Coprocessor Register Access Port

This block is the slave end of a pipelined coprocessor link. A processor uses the link to read and write a small set of system registers. Each transfer is split in time. In the cycle where the enable strobe is high, the port takes the direction flag and a 15-bit encoded register address. Two cycles later, the processor supplies the write data, two security control bits and a late commit strobe. A transfer whose commit strobe is low in that cycle is dropped and leaves no trace.

A short shift pipeline carries each captured request to the commit cycle, so a new transfer may start on every clock. The encoded address is split into its fields and matched against a small bank of example registers:

- a plain control register, which is also driven out on a dedicated port,
- a read-only identity value,
- a general scratch register,
- a register that only secure accesses may touch.

Read data appears combinationally in the commit cycle of a committed read. At every other time the read data is zero.

Top module: `sysreg_cp_port`

## Requirements
- R1: During and after synchronous active-low reset, every writable register is zero, `cp_rdata` is zero and `ctl_reg` is zero.
- R2: The address is decoded as follows:
  - Field positions: bits [14:12] are opcode-1, bits [11:8] are the primary register number, bits [7:4] are the secondary register number, bit 3 selects the coprocessor (0 selects cp14, 1 selects cp15) and bits [2:0] are opcode-2.
  - Register k sits at cp14 with opcode-1 = 1, primary = 0, secondary = k and opcode-2 = 0. This gives the address 15'h1000 + 16*k.
- R3: Direction and address are taken only in the cycle when `cp_en` is high. Their values in later cycles have no effect on that transfer.
- R4: Write data, security bits and commit are taken exactly two cycles after the enable cycle. A committed write updates the register at the clock edge that ends that cycle. Values on these inputs in the intermediate cycle have no effect.
- R5: A transfer whose commit is low in its commit cycle changes no register, and `cp_rdata` stays zero in that cycle.
- R6: For a committed read, `cp_rdata` shows the register value during the commit cycle. In all other cycles `cp_rdata` is zero.
- R7: Any address outside the mapped set reads as zero and writes to it change nothing. This covers cp15, any other opcode-1, primary or opcode-2 value, and a secondary number of 4 or more.
- R8: Transfers may be enabled on consecutive cycles and each one completes. A read whose commit cycle directly follows a committed write to the same register returns the newly written value.
- R9: Register 1 always reads the identity value 32'h1C5A_0001, and writes to it are ignored.
- R10: Register 3 is secure-only. `cp_sec[0]`=1 marks a non-secure access. A non-secure write to register 3 is ignored and a non-secure read of it returns zero. `cp_sec[1]` has no effect.
- R11: `ctl_reg` always equals the contents of register 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cp_en | input | 1 | Transfer start; direction and address valid |
| cp_wr | input | 1 | Direction, 1 = write |
| cp_addr | input | 15 | Encoded register address |
| cp_commit | input | 1 | Late commit strobe, two cycles after start |
| cp_sec | input | 2 | Security control, bit 0 = non-secure |
| cp_wdata | input | 32 | Write data, two cycles after start |
| cp_rdata | output | 32 | Read data in the commit cycle |
| ctl_reg | output | 32 | Current control register value |

## Verification
The bench builds the block with its default parameters. These are four registers, the read-only slot at index 1, the secure-only slot at index 3 and a commit latency of two. With these values a plain register, the read-only variant and the secure variant all exist side by side, and a secondary number of 4 lands just past the mapped range. The vector walk issues one transfer per cycle, so every commit overlaps the next two enables. This exposes read-after-write ordering and shows whether pipeline stages are aliased. Directed steps then change the address, direction and commit inputs in the cycles between enable and commit, and apply a reset in the middle of operation.

// File: rtl/cp_port_pkg.sv
// Package: shared types for the coprocessor register port.
// Assumes the 15-bit address layout documented in the brief (R2).
package cp_port_pkg;

    localparam int DATA_W = 32;

    // Encoded address, most significant field first.
    typedef struct packed {
        logic [2:0] opc1;
        logic [3:0] crn;
        logic [3:0] crm;
        logic       is_cp15;
        logic [2:0] opc2;
    } cp_addr_t;

    // Request carried down the pipeline.
    typedef struct packed {
        logic     vld;
        logic     wr;
        cp_addr_t addr;
    } cp_req_t;

endpackage

// File: rtl/cp_xfer_pipe.sv
// cp_xfer_pipe: holds each captured request for LATENCY cycles so that
// it lines up with the late data/commit inputs. A new request can be
// accepted on every clock. Assumes LATENCY >= 1.
module cp_xfer_pipe
    import cp_port_pkg::*;
#(
    parameter int LATENCY = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     in_vld,
    input  logic     in_wr,
    input  cp_addr_t in_addr,
    output cp_req_t  out_req
);

    cp_req_t stg [LATENCY];

    for (genvar g = 0; g < LATENCY; g++) begin : g_stage
        if (g == 0) begin : g_head
            // Capture direction and address in the enable cycle.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[0] <= '0;
                else        stg[0] <= '{vld: in_vld, wr: in_wr, addr: in_addr};
            end

            // R8
            s1_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
                in_vld |=> stg[0].vld);
        end else begin : g_body
            // Advance the request one stage.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[g] <= '0;
                else        stg[g] <= stg[g-1];
            end

            // R8
            stage_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
                stg[g-1].vld |=> (stg[g].vld && stg[g].addr == $past(stg[g-1].addr)));
        end
    end

    assign out_req = stg[LATENCY-1];

endmodule

// File: rtl/cp_addr_decode.sv
// cp_addr_decode: matches an encoded address against the register window
// (cp14, fixed opcode-1/primary/opcode-2, secondary = index).
// Assumes NUM_REGS <= 16 so the index fits the secondary field.
module cp_addr_decode
    import cp_port_pkg::*;
#(
    parameter int          NUM_REGS = 4,
    parameter int          IDX_W    = 2,
    parameter logic [2:0]  OPC1_SEL = 3'd1,
    parameter logic [3:0]  CRN_SEL  = 4'd0,
    parameter logic [2:0]  OPC2_SEL = 3'd0
) (
    input  cp_addr_t         addr,
    output logic             hit,
    output logic [IDX_W-1:0] idx
);

    // Field compare and range check on the secondary number.
    always_comb begin
        hit = !addr.is_cp15
              && (addr.opc1 == OPC1_SEL)
              && (addr.crn  == CRN_SEL)
              && (addr.opc2 == OPC2_SEL)
              && (32'(addr.crm) < NUM_REGS);
        idx = addr.crm[IDX_W-1:0];
    end

endmodule

// File: rtl/cp_reg_bank.sv
// cp_reg_bank: example register bank. One slot is a read-only constant,
// one slot is secure-only, the rest are plain 32-bit registers.
// Assumes the caller only raises wr_en for a decoded hit.
module cp_reg_bank
    import cp_port_pkg::*;
#(
    parameter int               NUM_REGS = 4,
    parameter int               IDX_W    = 2,
    parameter int               RO_IDX   = 1,
    parameter int               SEC_IDX  = 3,
    parameter logic [DATA_W-1:0] ID_VALUE = 32'h1C5A_0001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wdata,
    input  logic              nonsec,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] slot0
);

    logic [DATA_W-1:0] q [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_slot
        if (g == RO_IDX) begin : g_ro
            assign q[g] = ID_VALUE;
        end else if (g == SEC_IDX) begin : g_sec
            // Secure-only slot: non-secure writes are dropped.
            always_ff @(posedge clk) begin
                if (!rst_n)                                       q[g] <= '0;
                else if (wr_en && wr_idx == IDX_W'(g) && !nonsec) q[g] <= wdata;
            end

            // R10
            secure_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && nonsec && wr_idx == IDX_W'(g)) |=> $stable(q[g]));
        end else begin : g_rw
            // Plain read/write slot.
            always_ff @(posedge clk) begin
                if (!rst_n)                             q[g] <= '0;
                else if (wr_en && wr_idx == IDX_W'(g))  q[g] <= wdata;
            end
        end
    end

    // Read mux; secure slot reads zero for non-secure callers.
    always_comb begin
        rdata = '0;
        for (int k = 0; k < NUM_REGS; k++) begin
            if (rd_idx == IDX_W'(k) && !(k == SEC_IDX && nonsec)) rdata = q[k];
        end
    end

    assign slot0 = q[0];

endmodule

// File: rtl/sysreg_cp_port.sv
// sysreg_cp_port: slave end of a pipelined coprocessor register link.
// Request (direction, address) arrives with cp_en; data, security bits
// and commit arrive LATENCY cycles later. Uncommitted transfers have no
// effect. Assumes LATENCY stays small (a few cycles).
module sysreg_cp_port
    import cp_port_pkg::*;
#(
    parameter int          NUM_REGS = 4,
    parameter int          LATENCY  = 2,
    parameter logic [2:0]  OPC1_SEL = 3'd1,
    parameter logic [3:0]  CRN_SEL  = 4'd0,
    parameter logic [2:0]  OPC2_SEL = 3'd0,
    parameter int          RO_IDX   = 1,
    parameter int          SEC_IDX  = 3,
    parameter logic [31:0] ID_VALUE = 32'h1C5A_0001
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cp_en,
    input  logic        cp_wr,
    input  logic [14:0] cp_addr,
    input  logic        cp_commit,
    input  logic [1:0]  cp_sec,
    input  logic [31:0] cp_wdata,
    output logic [31:0] cp_rdata,
    output logic [31:0] ctl_reg
);

    localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    cp_req_t           tail;
    logic              hit;
    logic [IDX_W-1:0]  idx;
    logic              fire, wr_fire, rd_fire;
    logic [DATA_W-1:0] bank_rd;
    logic              unused_sec;

    assign unused_sec = cp_sec[1];

    cp_xfer_pipe #(.LATENCY(LATENCY)) u_pipe (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_vld  (cp_en),
        .in_wr   (cp_wr),
        .in_addr (cp_addr_t'(cp_addr)),
        .out_req (tail)
    );

    cp_addr_decode #(
        .NUM_REGS (NUM_REGS),
        .IDX_W    (IDX_W),
        .OPC1_SEL (OPC1_SEL),
        .CRN_SEL  (CRN_SEL),
        .OPC2_SEL (OPC2_SEL)
    ) u_dec (
        .addr (tail.addr),
        .hit  (hit),
        .idx  (idx)
    );

    // Commit-cycle qualification of the pending request.
    always_comb begin
        fire    = tail.vld && cp_commit && hit;
        wr_fire = fire && tail.wr;
        rd_fire = fire && !tail.wr;
    end

    cp_reg_bank #(
        .NUM_REGS (NUM_REGS),
        .IDX_W    (IDX_W),
        .RO_IDX   (RO_IDX),
        .SEC_IDX  (SEC_IDX),
        .ID_VALUE (ID_VALUE)
    ) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_fire),
        .wr_idx (idx),
        .wdata  (cp_wdata),
        .nonsec (cp_sec[0]),
        .rd_idx (idx),
        .rdata  (bank_rd),
        .slot0  (ctl_reg)
    );

    // Present read data only during a committed read.
    assign cp_rdata = rd_fire ? bank_rd : '0;

    // R5
    cancel_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tail.vld && !cp_commit) |=> $stable(ctl_reg));

    // R6
    rdata_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cp_rdata != '0) |-> (tail.vld && !tail.wr && cp_commit));

endmodule

// File: tb/sysreg_cp_port_tb.sv
module sysreg_cp_port_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cp_en = 1'b0;
    logic        cp_wr = 1'b0;
    logic [14:0] cp_addr = '0;
    logic        cp_commit = 1'b0;
    logic [1:0]  cp_sec = '0;
    logic [31:0] cp_wdata = '0;
    logic [31:0] cp_rdata;
    logic [31:0] ctl_reg;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    sysreg_cp_port u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cp_en     (cp_en),
        .cp_wr     (cp_wr),
        .cp_addr   (cp_addr),
        .cp_commit (cp_commit),
        .cp_sec    (cp_sec),
        .cp_wdata  (cp_wdata),
        .cp_rdata  (cp_rdata),
        .ctl_reg   (ctl_reg)
    );

    localparam logic [31:0] ID = 32'h1C5A_0001;
    localparam logic [14:0] A0 = 15'h1000, A1 = 15'h1010, A2 = 15'h1020, A3 = 15'h1030;

    // {wr, addr, wdata, sec, commit, expected rdata in commit cycle}
    localparam int NV = 21;
    localparam logic [82:0] VEC [NV] = '{
        {1'b1, A0,       32'hDEAD_0001, 2'b00, 1'b1, 32'h0},          // R4 write
        {1'b0, A0,       32'h0,         2'b00, 1'b1, 32'hDEAD_0001},  // R8 RAW
        {1'b1, A2,       32'h1234_5678, 2'b00, 1'b0, 32'h0},          // R5 cancelled
        {1'b0, A2,       32'h0,         2'b00, 1'b1, 32'h0},          // R5
        {1'b1, A2,       32'hCAFE_F00D, 2'b00, 1'b1, 32'h0},
        {1'b0, A2,       32'h0,         2'b00, 1'b0, 32'h0},          // R5 cancelled read
        {1'b0, A2,       32'h0,         2'b00, 1'b1, 32'hCAFE_F00D},  // R6
        {1'b1, A1,       32'hFFFF_FFFF, 2'b00, 1'b1, 32'h0},          // R9
        {1'b0, A1,       32'h0,         2'b00, 1'b1, ID},             // R9
        {1'b1, A3,       32'hAAAA_5555, 2'b01, 1'b1, 32'h0},          // R10 non-secure
        {1'b0, A3,       32'h0,         2'b00, 1'b1, 32'h0},          // R10
        {1'b1, A3,       32'h0BAD_0BAD, 2'b10, 1'b1, 32'h0},          // R10 sec[1]
        {1'b0, A3,       32'h0,         2'b01, 1'b1, 32'h0},          // R10 ns read
        {1'b0, A3,       32'h0,         2'b10, 1'b1, 32'h0BAD_0BAD},  // R10
        {1'b1, 15'h1008, 32'h1111_1111, 2'b00, 1'b1, 32'h0},          // R7 cp15
        {1'b0, 15'h1008, 32'h0,         2'b00, 1'b1, 32'h0},          // R7
        {1'b1, 15'h2000, 32'h2222_2222, 2'b00, 1'b1, 32'h0},          // R7 opc1
        {1'b0, A0,       32'h0,         2'b00, 1'b1, 32'hDEAD_0001},  // R2 no alias
        {1'b0, 15'h1001, 32'h0,         2'b00, 1'b1, 32'h0},          // R7 opc2
        {1'b0, 15'h1100, 32'h0,         2'b00, 1'b1, 32'h0},          // R7 crn
        {1'b0, 15'h1040, 32'h0,         2'b00, 1'b1, 32'h0}           // R7 crm range
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    // One isolated transfer; rd holds cp_rdata in the commit cycle.
    task automatic xfer(input logic wr, input logic [14:0] a, input logic [31:0] wd,
                        input logic [1:0] sec, input logic cm, output logic [31:0] rd);
        @(negedge clk); cp_en = 1'b1; cp_wr = wr; cp_addr = a;
        @(negedge clk); cp_en = 1'b0; cp_wr = 1'b0; cp_addr = '0;
        @(negedge clk); cp_commit = cm; cp_wdata = wd; cp_sec = sec;
        #1 rd = cp_rdata;
        @(negedge clk); cp_commit = 1'b0; cp_wdata = '0; cp_sec = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        check("R1 reset rdata", cp_rdata, 32'h0);
        check("R1 reset ctl_reg", ctl_reg, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset ctl_reg", ctl_reg, 32'h0);

        // Vector walk: one enable per cycle, commits trail by two.
        for (int i = 0; i < NV + 2; i++) begin
            @(negedge clk);
            if (i < NV) begin
                cp_en = 1'b1; cp_wr = VEC[i][82]; cp_addr = VEC[i][81:67];
            end else begin
                cp_en = 1'b0; cp_wr = 1'b0; cp_addr = '0;
            end
            if (i >= 2) begin
                cp_wdata = VEC[i-2][66:35]; cp_sec = VEC[i-2][34:33]; cp_commit = VEC[i-2][32];
                #1 check($sformatf("R6 vector %0d", i - 2), cp_rdata, VEC[i-2][31:0]);
            end
        end
        @(negedge clk); cp_commit = 1'b0; cp_wdata = '0; cp_sec = '0;
        check("R11 ctl_reg after walk", ctl_reg, 32'hDEAD_0001);

        // R3/R4: inputs toggled between enable and commit are ignored.
        @(negedge clk); cp_en = 1'b1; cp_wr = 1'b1; cp_addr = A0;
        @(negedge clk); cp_en = 1'b0; cp_wr = 1'b0; cp_addr = A2;
        cp_commit = 1'b1; cp_wdata = 32'hFFFF_0000;
        @(negedge clk); cp_addr = '0; cp_commit = 1'b1; cp_wdata = 32'h0000_55AA;
        @(negedge clk); cp_commit = 1'b0; cp_wdata = '0;
        #1 check("R4 ctl_reg late data", ctl_reg, 32'h0000_55AA);
        check("R3 commit-cycle rdata after write", cp_rdata, 32'h0);
        xfer(1'b0, A0, 32'h0, 2'b00, 1'b1, rd);
        check("R3 A0 read", rd, 32'h0000_55AA);
        xfer(1'b0, A2, 32'h0, 2'b00, 1'b1, rd);
        check("R3 A2 untouched", rd, 32'hCAFE_F00D);

        // R5: cancelled write to control register.
        xfer(1'b1, A0, 32'h7777_7777, 2'b00, 1'b0, rd);
        check("R5 cancelled write ctl_reg", ctl_reg, 32'h0000_55AA);
        check("R5 cancelled write rdata", rd, 32'h0);

        // R1: reset in the middle of operation.
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check("R1 mid reset ctl_reg", ctl_reg, 32'h0);
        xfer(1'b0, A2, 32'h0, 2'b00, 1'b1, rd);
        check("R1 mid reset A2", rd, 32'h0);
        xfer(1'b0, A1, 32'h0, 2'b00, 1'b1, rd);
        check("R9 ID after reset", rd, ID);

        summary();
    end

endmodule